// File: doc/BRIEF.md
# Audio Master Clock and Serial Port

This block is the clock-master end of a stereo audio output path. It runs on a 24.576 MHz system clock, which is 512 times a 48 kHz sample rate. From that clock it derives a master clock for converters, a bit clock and a word-select (LR) clock. In the same clock domain it shifts a stereo pair of 24-bit samples out on one serial data line.

Software-side logic sets the run-time configuration:

- the bit-clock ratio (32 or 64 per sample period);
- the master-clock ratio (256 or 512 per sample period);
- a master-clock stop bit;
- the justification format: I2S, left-justified or right-justified.

A new configuration is latched only where a frame starts. Once per frame the block asks for the next sample pair with a one-cycle request pulse. If no fresh pair has been handed in by the end of the frame, the last pair is sent again.

Top module: `aud_master_port`

## Requirements
- R1: During reset and throughout the first frame after it, the block uses its default settings whatever the configuration inputs say. The defaults are a 64 fs bit clock, a 256 fs master clock that is running, and I2S format. The stored sample pair resets to zero, so serial data is 0.
- R2: One frame spans 512 system-clock cycles, counted from the first cycle after reset. In 64 fs mode each bit slot lasts 8 cycles: the bit clock is low for the first 4 and high for the last 4. In 32 fs mode each slot lasts 16 cycles: low for 8, high for 8. Every frame starts with the bit clock low.
- R3: The LR clock changes only at the frame start and at mid-frame (cycle 256). The first half-frame carries the left channel. With format code 2'b00 (I2S) or the spare code 2'b11, LR is low in the left half. With 2'b01 (left-justified) or 2'b10 (right-justified), LR is high in the left half.
- R4: Serial data changes only while the bit clock is low, so it is steady across each rising edge. Words go out MSB first. In I2S at 64 fs, slot 0 of each half is 0, slots 1 to 24 carry sample bits 23 down to 0, and the remaining slots are 0.
- R5: In left-justified format at 64 fs, slots 0 to 23 of each half carry bits 23 down to 0, and slots 24 to 31 are 0.
- R6: In right-justified format at 64 fs, slots 0 to 7 of each half are 0 and slots 8 to 31 carry bits 23 down to 0, so the LSB lands in the last slot.
- R7: At 32 fs each half holds 16 slots and only bits 23 to 8 are sent. Left- and right-justified then both put bit 23 in slot 0. I2S puts bit 23 in slot 1. Slot 0 of an I2S half carries bit 8 of the channel before it: the previous frame's right word for the left half, and the current left word for the right half.
- R8: With the 512 fs select set, the master clock is a copy of the system clock. With it clear, the master clock toggles every cycle and is low in the first cycle of each frame. With the stop bit set, it is held low.
- R9: A change on any configuration input takes effect at the next frame start, never inside a frame.
- R10: The request pulse is high for exactly one cycle per frame, at cycle 480. A pair given with the valid strobe at any cycle up to and including cycle 511 of a frame is sent in the next frame. If no valid pair arrives, the previous pair is repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 24.576 MHz system clock |
| rst_i | input | 1 | synchronous reset, active high |
| cfg_bck32_i | input | 1 | 1: bit clock at 32 fs, 0: at 64 fs |
| cfg_mclk512_i | input | 1 | 1: master clock at 512 fs, 0: at 256 fs |
| cfg_mclk_stop_i | input | 1 | 1: master clock held low |
| cfg_fmt_i | input | 2 | 00 I2S, 01 left-justified, 10 right-justified, 11 as I2S |
| smp_left_i | input | 24 | left sample, two's complement |
| smp_right_i | input | 24 | right sample, two's complement |
| smp_valid_i | input | 1 | strobe marking a new sample pair |
| mclk_o | output | 1 | master clock for converters |
| bclk_o | output | 1 | bit clock |
| lrclk_o | output | 1 | LR word-select clock |
| sdata_o | output | 1 | serial audio data |
| smp_req_o | output | 1 | one-cycle request for the next pair |

## Verification
If the frame counter drifts or skips, the LR clock, the bit clock and the request pulse all move off their fixed cycles within one frame. A wrong bit-slot decode shows up in the very frame in which that format and ratio are first used, as a misplaced MSB or a misplaced carry bit. A wrong configuration latch shows up inside the frame where an input changes: the bit-clock period or the master clock changes before the frame start. A lost or stale pending pair shows up one frame after the valid strobe, as the wrong word on the data line.

// File: rtl/aud_pkg.sv
`timescale 1ns/1ps
package aud_pkg;

    localparam int SAMPLE_W = 24;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic [1:0] {
        FMT_I2S   = 2'b00,
        FMT_LEFT  = 2'b01,
        FMT_RIGHT = 2'b10,
        FMT_SPARE = 2'b11
    } fmt_e;

    typedef struct packed {
        logic bck32;
        logic mclk512;
        logic mclk_stop;
        fmt_e fmt;
    } port_cfg_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } pair_t;

    localparam port_cfg_t CFG_RESET = '{bck32: 1'b0, mclk512: 1'b0,
                                        mclk_stop: 1'b0, fmt: FMT_I2S};

    // word-select level for a half frame
    function automatic logic lr_level(fmt_e f, logic right_half);
        return (f == FMT_LEFT || f == FMT_RIGHT) ? ~right_half : right_half;
    endfunction

    // value of one bit slot inside a half frame
    function automatic logic slot_bit(fmt_e f, logic bck32, sample_t word,
                                      logic [4:0] slot, logic carry);
        int half;
        int emit;
        int first;
        int pos;
        sample_t shifted;
        logic bit_v;
        half    = bck32 ? 16 : 32;
        emit    = (SAMPLE_W < half) ? SAMPLE_W : half;
        pos     = int'(slot);
        shifted = '0;
        bit_v   = 1'b0;
        case (f)
            FMT_LEFT:  first = 0;
            FMT_RIGHT: first = half - emit;
            default:   first = 1;
        endcase
        if (pos >= first && pos < first + emit) begin
            shifted = word << (pos - first);
            bit_v   = shifted[SAMPLE_W-1];
        end else if (first == 1 && pos == 0 && emit == half) begin
            bit_v = carry;
        end
        return bit_v;
    endfunction

endpackage

// File: rtl/aud_timebase.sv
`timescale 1ns/1ps
module aud_timebase
    import aud_pkg::*;
#(
    parameter int CLK_PER_FS = 512,
    parameter int REQ_LEAD   = 32
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  port_cfg_t                     cfg_req_i,
    output logic [$clog2(CLK_PER_FS)-1:0] phase_o,
    output logic                          frame_end_o,
    output port_cfg_t                     cfg_act_o,
    output logic                          req_o
);
    localparam int CW = $clog2(CLK_PER_FS);
    localparam logic [CW-1:0] LAST   = CW'(CLK_PER_FS - 1);
    localparam logic [CW-1:0] REQ_AT = CW'(CLK_PER_FS - REQ_LEAD);

    logic [CW-1:0] phase_q;
    port_cfg_t     cfg_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= '0;
            cfg_q   <= CFG_RESET;
        end else begin
            phase_q <= phase_q + CW'(1);
            if (phase_q == LAST) begin
                cfg_q <= cfg_req_i;
            end
        end
    end

    assign phase_o     = phase_q;
    assign frame_end_o = (phase_q == LAST);
    assign cfg_act_o   = cfg_q;
    assign req_o       = (phase_q == REQ_AT);

endmodule

// File: rtl/aud_mclk_gen.sv
`timescale 1ns/1ps
module aud_mclk_gen
    import aud_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  port_cfg_t cfg_i,
    output logic      mclk_o
);
    logic half_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            half_q <= 1'b0;
        end else begin
            half_q <= ~half_q;
        end
    end

    always_comb begin
        if (cfg_i.mclk_stop) begin
            mclk_o = 1'b0;
        end else if (cfg_i.mclk512) begin
            mclk_o = clk_i;
        end else begin
            mclk_o = half_q;
        end
    end

endmodule

// File: rtl/aud_serializer.sv
`timescale 1ns/1ps
module aud_serializer
    import aud_pkg::*;
#(
    parameter int CLK_PER_FS = 512
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic [$clog2(CLK_PER_FS)-1:0] phase_i,
    input  logic                          frame_end_i,
    input  port_cfg_t                     cfg_i,
    input  pair_t                         pair_i,
    input  logic                          valid_i,
    output logic                          bclk_o,
    output logic                          lrclk_o,
    output logic                          sdata_o
);
    localparam int CW        = $clog2(CLK_PER_FS);
    localparam int SH        = $clog2(CLK_PER_FS / 64);
    localparam int SPILL_IDX = SAMPLE_W - 16;

    pair_t pend_q;
    pair_t cur_q;
    logic  spill_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q  <= '0;
            cur_q   <= '0;
            spill_q <= 1'b0;
        end else begin
            if (valid_i) begin
                pend_q <= pair_i;
            end
            if (frame_end_i) begin
                cur_q   <= valid_i ? pair_i : pend_q;
                spill_q <= cur_q.right[SPILL_IDX];
            end
        end
    end

    logic       right_half;
    logic [4:0] slot;
    sample_t    word;
    logic       carry;

    always_comb begin
        right_half = phase_i[CW-1];
        slot       = cfg_i.bck32 ? {1'b0, phase_i[CW-2 -: 4]} : phase_i[CW-2 -: 5];
        bclk_o     = cfg_i.bck32 ? phase_i[SH] : phase_i[SH-1];
        lrclk_o    = lr_level(cfg_i.fmt, right_half);
        word       = right_half ? cur_q.right : cur_q.left;
        carry      = right_half ? cur_q.left[SPILL_IDX] : spill_q;
        sdata_o    = slot_bit(cfg_i.fmt, cfg_i.bck32, word, slot, carry);
    end

endmodule

// File: rtl/aud_master_port.sv
`timescale 1ns/1ps
module aud_master_port
    import aud_pkg::*;
#(
    parameter int CLK_PER_FS = 512,
    parameter int REQ_LEAD   = 32
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                cfg_bck32_i,
    input  logic                cfg_mclk512_i,
    input  logic                cfg_mclk_stop_i,
    input  logic [1:0]          cfg_fmt_i,
    input  logic [SAMPLE_W-1:0] smp_left_i,
    input  logic [SAMPLE_W-1:0] smp_right_i,
    input  logic                smp_valid_i,
    output logic                mclk_o,
    output logic                bclk_o,
    output logic                lrclk_o,
    output logic                sdata_o,
    output logic                smp_req_o
);
    localparam int CW = $clog2(CLK_PER_FS);

    port_cfg_t     cfg_req;
    port_cfg_t     cfg_act;
    pair_t         pair_in;
    logic [CW-1:0] phase;
    logic          frame_end;

    always_comb begin
        cfg_req.bck32     = cfg_bck32_i;
        cfg_req.mclk512   = cfg_mclk512_i;
        cfg_req.mclk_stop = cfg_mclk_stop_i;
        cfg_req.fmt       = fmt_e'(cfg_fmt_i);
        pair_in.left      = smp_left_i;
        pair_in.right     = smp_right_i;
    end

    aud_timebase #(
        .CLK_PER_FS(CLK_PER_FS),
        .REQ_LEAD  (REQ_LEAD)
    ) u_tb (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .cfg_req_i  (cfg_req),
        .phase_o    (phase),
        .frame_end_o(frame_end),
        .cfg_act_o  (cfg_act),
        .req_o      (smp_req_o)
    );

    aud_mclk_gen u_mclk (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .cfg_i (cfg_act),
        .mclk_o(mclk_o)
    );

    aud_serializer #(
        .CLK_PER_FS(CLK_PER_FS)
    ) u_ser (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .phase_i    (phase),
        .frame_end_i(frame_end),
        .cfg_i      (cfg_act),
        .pair_i     (pair_in),
        .valid_i    (smp_valid_i),
        .bclk_o     (bclk_o),
        .lrclk_o    (lrclk_o),
        .sdata_o    (sdata_o)
    );

endmodule

// File: rtl/aud_master_port_chk.sv
`timescale 1ns/1ps
module aud_master_port_chk #(
    parameter int CLK_PER_FS = 512,
    parameter int REQ_LEAD   = 32
) (
    input logic clk_i,
    input logic rst_i,
    input logic bclk_o,
    input logic lrclk_o,
    input logic sdata_o,
    input logic smp_req_o
);
    localparam int CW = $clog2(CLK_PER_FS);
    localparam logic [CW-1:0] HALF   = CW'(CLK_PER_FS / 2);
    localparam logic [CW-1:0] REQ_AT = CW'(CLK_PER_FS - REQ_LEAD);

    logic [CW-1:0] ph_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + CW'(1);
        end
    end

    // R2: each frame opens with the bit clock low
    a_r2_frame_starts_low: assert property (@(posedge clk_i) disable iff (rst_i)
        (ph_q == '0) |-> !bclk_o);

    // R3: word select moves only at the two half-frame boundaries
    a_r3_lr_holds_within_half: assert property (@(posedge clk_i) disable iff (rst_i)
        (ph_q != '0 && ph_q != HALF) |-> $stable(lrclk_o));

    // R4: data does not move while the bit clock is high
    a_r4_data_steady_when_high: assert property (@(posedge clk_i) disable iff (rst_i)
        bclk_o |-> $stable(sdata_o));

    // R10: request only at its fixed cycle
    a_r10_req_position: assert property (@(posedge clk_i) disable iff (rst_i)
        smp_req_o |-> (ph_q == REQ_AT));

    // R10: request lasts one cycle
    a_r10_req_single: assert property (@(posedge clk_i) disable iff (rst_i)
        smp_req_o |=> !smp_req_o);

endmodule

bind aud_master_port aud_master_port_chk #(
    .CLK_PER_FS(CLK_PER_FS),
    .REQ_LEAD  (REQ_LEAD)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .bclk_o   (bclk_o),
    .lrclk_o  (lrclk_o),
    .sdata_o  (sdata_o),
    .smp_req_o(smp_req_o)
);

// File: tb/sim_aud_master_port.sv
`timescale 1ns/1ps
module sim_aud_master_port;
    localparam int FRAME  = 512;
    localparam int REQ_AT = FRAME - 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst;
    logic        bck32, m512, mstop, valid;
    logic [1:0]  fmt;
    logic [23:0] lft, rgt;
    logic        mclk, bclk, lrclk, sd, req;

    int ph = 0;
    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    aud_master_port u0 (
        .clk_i          (clk),
        .rst_i          (rst),
        .cfg_bck32_i    (bck32),
        .cfg_mclk512_i  (m512),
        .cfg_mclk_stop_i(mstop),
        .cfg_fmt_i      (fmt),
        .smp_left_i     (lft),
        .smp_right_i    (rgt),
        .smp_valid_i    (valid),
        .mclk_o         (mclk),
        .bclk_o         (bclk),
        .lrclk_o        (lrclk),
        .sdata_o        (sdata_o_w),
        .smp_req_o      (req)
    );
    logic sdata_o_w;
    assign sd = sdata_o_w;

    always @(posedge clk) begin
        if (rst) ph <= 0;
        else     ph <= (ph + 1) % FRAME;
    end

    // {fmt, bck32, mclk mode (0:256 1:512 2:stop), left, right}
    localparam logic [52:0] VEC [7] = '{
        {2'd0, 1'b0, 2'd0, 24'hA5F00F, 24'h3C0FF1},
        {2'd1, 1'b0, 2'd1, 24'h800001, 24'h7FFFFE},
        {2'd2, 1'b0, 2'd2, 24'hC00003, 24'h123556},
        {2'd0, 1'b1, 2'd0, 24'h9ABDDE, 24'h654321},
        {2'd1, 1'b1, 2'd1, 24'hFEDCBA, 24'h0F1E2D},
        {2'd2, 1'b1, 2'd0, 24'h13579B, 24'h2468AC},
        {2'd3, 1'b0, 2'd0, 24'h5A5A5A, 24'hA5A5A5}
    };

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic report(input string tag, input string what, input int nbad,
                          input int p, input int act, input int exp);
        checks++;
        if (nbad > 0) begin
            bad++;
            $display("FAIL %s %s: %0d wrong cycles, first at cycle %0d actual=%0d expected=%0d",
                     tag, what, nbad, p, act, exp);
        end
    endtask

    function automatic logic exp_sd(int f, bit b32, logic [23:0] L, logic [23:0] R,
                                    logic [23:0] PR, int p);
        int per, half, nb, k, first;
        bit rh;
        logic [23:0] w;
        per   = b32 ? 16 : 8;
        half  = b32 ? 16 : 32;
        nb    = b32 ? 16 : 24;
        k     = (p / per) % half;
        rh    = p >= FRAME / 2;
        w     = rh ? R : L;
        first = (f == 1) ? 0 : ((f == 2) ? half - nb : 1);
        if (k >= first && k < first + nb) return w[23 - (k - first)];
        if (first == 1 && k == 0 && b32) return rh ? L[8] : PR[8];
        return 1'b0;
    endfunction

    function automatic string tag_of(int f, bit b32);
        if (b32) return "R7";
        if (f == 1) return "R5";
        if (f == 2) return "R6";
        if (f == 3) return "R3";
        return "R4";
    endfunction

    task automatic wait_ph(input int n);
        @(negedge clk);
        while (ph != n) @(negedge clk);
    endtask

    // checks one whole frame, entered at the negedge of its cycle 0
    task automatic check_now(input int f, input bit b32, input int mm, input logic [23:0] L,
                             input logic [23:0] R, input logic [23:0] PR, input string tag);
        int n_sd = 0, n_bc = 0, n_lr = 0, n_rq = 0, n_mc = 0;
        int p_sd = 0, p_bc = 0, p_lr = 0, p_rq = 0, p_mc = 0;
        int a_sd = 0, a_bc = 0, a_lr = 0, a_rq = 0, a_mc = 0;
        int x_sd = 0, x_bc = 0, x_lr = 0, x_rq = 0, x_mc = 0;
        for (int p = 0; p < FRAME; p++) begin
            int per;
            logic e_sd, e_bc, e_lr, e_rq, e_mc;
            per  = b32 ? 16 : 8;
            e_bc = (p % per) >= per / 2;
            e_lr = (f == 1 || f == 2) ? (p < FRAME / 2) : (p >= FRAME / 2);
            e_sd = exp_sd(f, b32, L, R, PR, p);
            e_rq = (p == REQ_AT);
            e_mc = (mm == 0) ? p[0] : 1'b0;
            if (sd !== e_sd)    begin if (n_sd == 0) begin p_sd = p; a_sd = sd;    x_sd = e_sd; end n_sd++; end
            if (bclk !== e_bc)  begin if (n_bc == 0) begin p_bc = p; a_bc = bclk;  x_bc = e_bc; end n_bc++; end
            if (lrclk !== e_lr) begin if (n_lr == 0) begin p_lr = p; a_lr = lrclk; x_lr = e_lr; end n_lr++; end
            if (req !== e_rq)   begin if (n_rq == 0) begin p_rq = p; a_rq = req;   x_rq = e_rq; end n_rq++; end
            if (mclk !== e_mc)  begin if (n_mc == 0) begin p_mc = p; a_mc = mclk;  x_mc = e_mc; end n_mc++; end
            @(negedge clk);
        end
        report(tag, "sdata", n_sd, p_sd, a_sd, x_sd);
        report((tag == "R1") ? "R1" : "R2", "bclk", n_bc, p_bc, a_bc, x_bc);
        report((tag == "R1") ? "R1" : "R3", "lrclk", n_lr, p_lr, a_lr, x_lr);
        report("R10", "request", n_rq, p_rq, a_rq, x_rq);
        report((tag == "R1") ? "R1" : "R8", "mclk", n_mc, p_mc, a_mc, x_mc);
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        #1600000;
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_up();
        end
    end

    logic [52:0] v;
    logic [23:0] prev_r;
    int          vf, vm;
    bit          vb;

    initial begin
        rst = 1'b1; bck32 = 1'b1; fmt = 2'b01; m512 = 1'b1; mstop = 1'b1;
        valid = 1'b0; lft = 24'h0; rgt = 24'h0;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "bclk in reset", int'(bclk), 0);
        chk("R1", "lrclk in reset", int'(lrclk), 0);
        chk("R1", "sdata in reset", int'(sd), 0);
        chk("R1", "request in reset", int'(req), 0);
        chk("R1", "mclk in reset", int'(mclk), 0);
        rst = 1'b0;
        // R1: first frame keeps defaults despite non-default inputs
        check_now(0, 1'b0, 0, 24'h0, 24'h0, 24'h0, "R1");

        prev_r = 24'h0;
        for (int i = 0; i < 7; i++) begin
            v  = VEC[i];
            vf = int'(v[52:51]);
            vb = v[50];
            vm = int'(v[49:48]);
            wait_ph(100);
            fmt = v[52:51]; bck32 = vb; m512 = (vm == 1); mstop = (vm == 2);
            lft = v[47:24]; rgt = v[23:0]; valid = 1'b1;
            @(negedge clk);
            valid = 1'b0;
            wait_ph(0);
            check_now(vf, vb, vm, v[47:24], v[23:0], prev_r, tag_of(vf, vb));
            prev_r = v[23:0];
        end
        // R10: no new pair, so the last one repeats
        check_now(vf, vb, vm, v[47:24], v[23:0], prev_r, "R10");

        // R8: 512 fs copy of the clock, then stop
        m512 = 1'b1; mstop = 1'b0;
        wait_ph(0);
        wait_ph(20);
        @(posedge clk); #1;
        chk("R8", "mclk high phase at 512fs", int'(mclk), 1);
        @(negedge clk);
        chk("R8", "mclk low phase at 512fs", int'(mclk), 0);
        mstop = 1'b1;
        @(posedge clk); #1;
        chk("R9", "mclk before boundary", int'(mclk), 1);
        wait_ph(0);
        wait_ph(30);
        @(posedge clk); #1;
        chk("R8", "mclk stopped high phase", int'(mclk), 0);
        @(negedge clk);
        chk("R8", "mclk stopped low phase", int'(mclk), 0);

        // R9: bit-clock ratio change mid-frame waits for the boundary
        wait_ph(0);
        wait_ph(2);
        bck32 = 1'b1;
        begin
            int nb64 = 0, nb32 = 0, fp64 = 0, fp32 = 0, fa64 = 0, fa32 = 0;
            for (int p = 2; p < FRAME; p++) begin
                if (bclk !== ((p % 8) >= 4)) begin
                    if (nb64 == 0) begin fp64 = p; fa64 = bclk; end
                    nb64++;
                end
                @(negedge clk);
            end
            for (int p = 0; p < 64; p++) begin
                if (bclk !== ((p % 16) >= 8)) begin
                    if (nb32 == 0) begin fp32 = p; fa32 = bclk; end
                    nb32++;
                end
                @(negedge clk);
            end
            report("R9", "bclk old ratio kept", nb64, fp64, fa64, (fp64 % 8) >= 4);
            report("R9", "bclk new ratio applied", nb32, fp32, fa32, (fp32 % 16) >= 8);
        end

        // R10: pair given in the last cycle of a frame is used next frame
        fmt = 2'b01; bck32 = 1'b0; m512 = 1'b0; mstop = 1'b0;
        wait_ph(511);
        lft = 24'hC3A55A; rgt = 24'h3CA5A5; valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        check_now(1, 1'b0, 0, 24'hC3A55A, 24'h3CA5A5, prev_r, "R10");

        done = 1'b1;
        finish_up();
    end

endmodule